// File: doc/BRIEF.md
# Two-Stage Serial Bit-Clock Generator

This block derives the serial bit rate of a synchronous serial port from the peripheral clock. It uses two dividers in series. The first is a prescaler that takes only even values. The second is an 8-bit rate divisor. A full bit period lasts `prescale × (rate + 1)` input clocks. Within that period the block marks the two half-period boundaries where the shift engine toggles its serial clock. It also marks the end of each bit with a one-cycle enable and reports the current serial clock level.

Software chooses both divisor values. The block samples them into frame-local copies when a frame starts. A change made during a frame therefore cannot disturb it. Starting a frame clears both divider counters, so the first half period always has full width. Dropping the port enable stops all output activity at once. The block does no shifting of its own.

Top module: `spi_bitclk_gen`

## Requirements
- R1: After reset, and while no frame is running, `sclk_toggle`, `bit_tick` and `sclk_level` are all 0.
- R2: In a running frame with effective prescale P and rate value S, `sclk_toggle` pulses for one cycle every H = (P/2)·(S+1) clocks. The first pulse comes in the H-th cycle after the edge that started the frame.
- R3: `sclk_level` starts each frame at 0 and inverts after every `sclk_toggle`. `bit_tick` is high exactly in those toggle cycles where `sclk_level` is 1, so it marks the end of each full bit period of 2H clocks.
- R4: Bit 0 of `prescale_cfg` is ignored (treated as 0), and a resulting value below 2 is treated as 2. For example, 7 acts as 6, and 0 and 1 both act as 2.
- R5: Every rate value from 0 to 255 is honoured. The fastest setting (prescale 2, rate 0) toggles on every clock, giving a bit rate of half the input clock. The slowest (prescale 254, rate 255) gives a half period of 127·256 clocks.
- R6: `frame_start` asserted with `port_en` high starts a new frame, even if one is already running. It clears both counters and `sclk_level`, so the first half period after a restart is full width.
- R7: Changes to `prescale_cfg` or `rate_cfg` during a frame have no effect on the timing until the next `frame_start`.
- R8: With `port_en` low, the running frame ends and its counters clear one clock later. A `frame_start` pulse while `port_en` is low starts nothing.
- R9: `frame_stop`, with `port_en` high and no `frame_start` in the same cycle, ends the running frame. All outputs are 0 from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Serial port enable; low stops and clears the generator |
| frame_start | input | 1 | One-cycle pulse that starts or restarts a frame and samples the divisors |
| frame_stop | input | 1 | One-cycle pulse that ends the running frame |
| prescale_cfg | input | 8 | Even prescale value, 2 to 254 |
| rate_cfg | input | 8 | Rate divisor value, 0 to 255 |
| sclk_toggle | output | 1 | High for one cycle at each serial clock half-period boundary |
| bit_tick | output | 1 | High for one cycle at the end of each full bit period |
| sclk_level | output | 1 | Current half of the bit period (0 first half, 1 second half) |

## Verification
The bench targets several corner cases:
- The fastest setting. An off-by-one in either counter would insert idle cycles between toggles.
- Odd and sub-minimum prescale values. Using bit 0, or letting zero through, would give a different period or a counter that never wraps.
- A restart in the middle of a half period. A generator that does not clear its counters would produce a short first half.
- A divisor rewrite during a frame. Without frame-local copies the period would change at once.
- Disabling the port while `frame_start` is pulsed, and an explicit stop. A design that ignored either would keep toggling.

// File: rtl/spi_bitclk_pkg.sv
package spi_bitclk_pkg;
  localparam int PRESCALE_W = 8;
  localparam int RATE_W     = 8;
  localparam int HALF_PRE_W = PRESCALE_W - 1;

  typedef struct packed {
    logic [HALF_PRE_W-1:0] pre_lim;
    logic [RATE_W-1:0]     rate_lim;
  } div_cfg_t;
endpackage

// File: rtl/spi_div_stage.sv
module spi_div_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         cen,
  input  logic [W-1:0] limit,
  output logic         tick
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         hit;

  assign hit  = (cnt_q == limit);
  assign tick = cen & hit;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (cen) begin
      cnt_d = hit ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/spi_sclk_phase.sv
module spi_sclk_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic half_tick,
  output logic level,
  output logic bit_end
);
  logic level_q;
  logic level_d;

  assign level   = level_q;
  assign bit_end = half_tick & level_q;

  always_comb begin
    level_d = level_q;
    if (clr) begin
      level_d = 1'b0;
    end else if (half_tick) begin
      level_d = ~level_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
    end else begin
      level_q <= level_d;
    end
  end
endmodule

// File: rtl/spi_bitclk_gen.sv
module spi_bitclk_gen
  import spi_bitclk_pkg::*;
#(
  parameter int PW = PRESCALE_W,
  parameter int RW = RATE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          port_en,
  input  logic          frame_start,
  input  logic          frame_stop,
  input  logic [PW-1:0] prescale_cfg,
  input  logic [RW-1:0] rate_cfg,
  output logic          sclk_toggle,
  output logic          bit_tick,
  output logic          sclk_level
);
  localparam int HPW = PW - 1;

  logic          run_q;
  logic          run_d;
  logic [HPW-1:0] pre_lim_q;
  logic [HPW-1:0] pre_lim_d;
  logic [RW-1:0]  rate_lim_q;
  logic           start_go;
  logic           cnt_clr;
  logic           pre_tick;
  logic           half_tick;
  logic [HPW-1:0] half_pre;

  assign start_go = port_en & frame_start;
  assign cnt_clr  = ~port_en | frame_start | frame_stop;

  // Drop bit 0 of the prescale; the half value has a floor of 1.
  assign half_pre  = prescale_cfg[PW-1:1];
  assign pre_lim_d = (half_pre == '0) ? '0 : half_pre - 1'b1;

  always_comb begin
    run_d = run_q;
    if (!port_en) begin
      run_d = 1'b0;
    end else if (frame_start) begin
      run_d = 1'b1;
    end else if (frame_stop) begin
      run_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
    end else begin
      run_q <= run_d;
    end
  end

  // Frame-local divisor copies, loaded only when a frame starts.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_lim_q  <= '0;
      rate_lim_q <= '0;
    end else if (start_go) begin
      pre_lim_q  <= pre_lim_d;
      rate_lim_q <= rate_cfg;
    end
  end

  spi_div_stage #(.W(HPW)) u_prescale (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .cen   (run_q),
    .limit (pre_lim_q),
    .tick  (pre_tick)
  );

  spi_div_stage #(.W(RW)) u_rate (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .cen   (pre_tick),
    .limit (rate_lim_q),
    .tick  (half_tick)
  );

  spi_sclk_phase u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (cnt_clr),
    .half_tick (half_tick),
    .level     (sclk_level),
    .bit_end   (bit_tick)
  );

  assign sclk_toggle = half_tick;
endmodule

// File: rtl/spi_bitclk_gen_chk.sv
module spi_bitclk_gen_chk #(
  parameter int HPW = 7,
  parameter int RW  = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           port_en,
  input logic           frame_start,
  input logic           frame_stop,
  input logic           run_q,
  input logic [HPW-1:0] pre_lim_q,
  input logic [RW-1:0]  rate_lim_q,
  input logic           sclk_toggle,
  input logic           bit_tick,
  input logic           sclk_level
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !sclk_toggle && !sclk_level); // R1

  AST_BIT_IN_SECOND_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> sclk_toggle && sclk_level); // R3

  AST_LEVEL_INVERTS: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_toggle && port_en && !frame_start && !frame_stop)
      |=> (sclk_level != $past(sclk_level))); // R3

  AST_START_LEVEL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && frame_start) |=> !sclk_level); // R6

  AST_CFG_HELD_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !(port_en && frame_start) |=> $stable(pre_lim_q) && $stable(rate_lim_q)); // R7

  AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> !run_q && !sclk_toggle && !sclk_level); // R8

  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && frame_stop && !frame_start) |=> !sclk_toggle && !bit_tick); // R9
endmodule

bind spi_bitclk_gen spi_bitclk_gen_chk #(.HPW(PW-1), .RW(RW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .port_en     (port_en),
  .frame_start (frame_start),
  .frame_stop  (frame_stop),
  .run_q       (run_q),
  .pre_lim_q   (pre_lim_q),
  .rate_lim_q  (rate_lim_q),
  .sclk_toggle (sclk_toggle),
  .bit_tick    (bit_tick),
  .sclk_level  (sclk_level)
);

// File: tb/spi_bitclk_gen_tb.sv
`timescale 1ns/1ps
module spi_bitclk_gen_tb;
  logic       clk;
  logic       rst_n;
  logic       port_en;
  logic       frame_start;
  logic       frame_stop;
  logic [7:0] prescale_cfg;
  logic [7:0] rate_cfg;
  logic       sclk_toggle;
  logic       bit_tick;
  logic       sclk_level;

  int    errors = 0;
  int    checks = 0;
  string tag = "R1";
  bit    done = 0;

  // Behavioural reference state
  bit m_run = 0;
  int m_cnt = 0;
  int m_half = 1;

  spi_bitclk_gen u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .port_en      (port_en),
    .frame_start  (frame_start),
    .frame_stop   (frame_stop),
    .prescale_cfg (prescale_cfg),
    .rate_cfg     (rate_cfg),
    .sclk_toggle  (sclk_toggle),
    .bit_tick     (bit_tick),
    .sclk_level   (sclk_level)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  function automatic int half_of(input int p, input int s);
    int pe;
    pe = p & 254;
    if (pe < 2) pe = 2;
    return (pe / 2) * (s + 1);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0;
      m_cnt = 0;
    end else if (!port_en) begin
      m_run = 0;
    end else if (frame_start) begin
      m_run = 1;
      m_cnt = 0;
      m_half = half_of(prescale_cfg, rate_cfg);
    end else if (frame_stop) begin
      m_run = 0;
    end else if (m_run) begin
      m_cnt++;
    end
  end

  task automatic chk(input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    logic e_tog, e_lvl;
    #2;
    if (rst_n && !done) begin
      e_tog = m_run && (((m_cnt + 1) % m_half) == 0);
      e_lvl = m_run && (((m_cnt / m_half) % 2) == 1);
      chk("sclk_toggle", sclk_toggle, e_tog);
      chk("sclk_level", sclk_level, e_lvl);
      chk("bit_tick", bit_tick, e_tog && e_lvl);
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start(input int p, input int s);
    @(negedge clk);
    prescale_cfg = p[7:0];
    rate_cfg     = s[7:0];
    frame_start  = 1;
    @(negedge clk);
    frame_start  = 0;
  endtask

  initial begin
    rst_n = 0; port_en = 0; frame_start = 0; frame_stop = 0;
    prescale_cfg = 8'd2; rate_cfg = 8'd0;
    cycles(3);
    rst_n = 1;
    // R1: idle after reset, even with the port enabled
    tag = "R1"; cycles(4);
    port_en = 1; cycles(4);
    // R5: fastest setting toggles every clock
    tag = "R5"; start(2, 0); cycles(20);
    // R2 and R3: general divisor, H = 3*3 = 9
    tag = "R2"; start(6, 2); cycles(40);
    tag = "R3"; start(4, 3); cycles(40);
    // R4: odd and sub-minimum prescale values
    tag = "R4"; start(7, 1); cycles(30);
    start(0, 3); cycles(20);
    start(1, 0); cycles(10);
    start(255, 0); cycles(300);
    // R6: restart mid half period
    tag = "R6"; start(10, 1); cycles(7);
    start(10, 1); cycles(30);
    // R7: divisor rewrite during a frame
    tag = "R7"; start(4, 1); cycles(5);
    prescale_cfg = 8'd20; rate_cfg = 8'd5; cycles(20);
    start(20, 5); cycles(130);
    // R8: disable, with start pulses while disabled
    tag = "R8"; start(4, 0); cycles(3);
    port_en = 0; cycles(2);
    frame_start = 1; cycles(2); frame_start = 0; cycles(3);
    port_en = 1; cycles(5);
    // R9: explicit stop
    tag = "R9"; start(6, 0); cycles(4);
    frame_stop = 1; cycles(1); frame_stop = 0; cycles(10);
    // R5: slowest setting, just over one full bit period
    tag = "R5"; start(254, 255); cycles(65040);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    done = 1;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule